// File: doc/BRIEF.md
# Register-Exchange Survivor Path Decoder

This block is the back end of a sixteen-state, rate one-half convolutional decoder. Each trellis step arrives from an add-compare-select stage as a valid strobe with a vector of decisions and the updated path metric of every state. The block keeps one survivor register per state. On every accepted step, each register takes on a copy of the register of the predecessor chosen by its decision and appends the newest information bit. The decoded bits therefore need no trace-back pass and leave at the same rate that steps arrive.

State numbering follows the encoder shift register. The newest input bit is the state's most significant bit, so the encoder moves from state s to state {u, s[3:1]}. Once a state's survivor holds a full window of 32 bits, every further step releases the oldest bit on the path that ends in the state with the smallest metric. A step marked as the last of a frame starts a drain. The bits still held in the survivor of state 0 leave oldest first, one per cycle. This relies on the tail bits having returned the encoder to state 0. The final bit is marked with a done pulse. A frame-start strobe discards everything held.

Top module: `rex_smu`

## Requirements
- R1: While reset is asserted, and after it is released with no step accepted, `bit_valid_o` and `frame_done_o` are low.
- R2: On an accepted step, the survivor of state n becomes the survivor of predecessor {n[2:0], decision_i[n]}, shifted one place toward older positions, with n[3] inserted as the newest bit.
- R3: The first 32 accepted steps of a frame produce no normal output. Each accepted step from the 33rd onward produces exactly one decoded bit, with `bit_valid_o` high in the cycle after the step is accepted. Frames of 32 steps or fewer therefore emit bits only through the drain.
- R4: A normal output bit is the oldest bit on the path ending in the state whose unsigned metric in `path_metrics_i` (state i in bits [8i+7:8i]) is smallest after the step.
- R5: When several states share the smallest metric, the one with the lowest index is chosen.
- R6: A step accepted with `frame_last_i` high starts a drain. In each of the following cycles, one bit from the survivor of state 0 leaves oldest first. This continues until all min(N, 32) held bits are out, so a frame of N steps yields exactly N bits in order.
- R7: `frame_done_o` is high for exactly one cycle, the cycle that carries the last bit of the frame. After that, a new frame may begin with or without a frame-start strobe.
- R8: A cycle with `step_valid_i` low leaves the survivors unchanged and outputs nothing, whatever the decision and metric inputs carry.
- R9: `frame_start_i` takes priority over every other input. It clears all survivors, the fill count and any drain, and no bit or done flag follows in the next cycle.
- R10: Steps presented during a drain are ignored and do not disturb the drained bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Clears all survivor state |
| step_valid_i | input | 1 | One trellis step is present this cycle |
| frame_last_i | input | 1 | The present step is the final step of the frame |
| decision_i | input | 16 | Bit n selects the predecessor of state n |
| path_metrics_i | input | 128 | Sixteen unsigned 8-bit metrics after this step |
| bit_o | output | 1 | Decoded information bit |
| bit_valid_o | output | 1 | `bit_o` holds a decoded bit |
| frame_done_o | output | 1 | Pulse with the last decoded bit of a frame |

## Verification
The bench encodes random frames. It marks the true state of each step with the smallest metric and fills every other state's decisions with noise, so only a correct exchange network and a correct selection recover the message. Frames of 10, 32, 33 and longer lengths target the fill boundary. An off-by-one in the fill count would release a bit too early or too late, or drain the wrong number of bits. A tie frame gives the true state equal metrics with all higher-numbered states, so a selector that prefers the highest index decodes noise. Idle cycles carry garbage inputs, steps arrive during the drain, and a frame is abandoned part-way. A design that advanced on idle cycles, let a late step shift the state 0 survivor, or kept a stale fill count would misorder or miscount the output stream.

// File: rtl/rex_pkg.sv
package rex_pkg;

    localparam int unsigned REX_STATES   = 16;
    localparam int unsigned REX_WINDOW   = 32;
    localparam int unsigned REX_METRIC_W = 8;

    // Lower of the two predecessors of a state: shift the state left, drop the top bit.
    function automatic int unsigned pred_base(input int unsigned n, input int unsigned states);
        return (n * 2) % states;
    endfunction

endpackage

// File: rtl/rex_cell.sv
module rex_cell #(
    parameter int unsigned WINDOW  = 32,
    parameter logic        NEW_BIT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              advance_i,
    input  logic              sel_i,
    input  logic [WINDOW-1:0] pred0_i,
    input  logic [WINDOW-1:0] pred1_i,
    output logic [WINDOW-1:0] surv_o,
    output logic              drop_o
);

    logic [WINDOW-1:0] pick;
    logic [WINDOW-1:0] surv_d;
    logic [WINDOW-1:0] surv_q;

    assign pick   = sel_i ? pred1_i : pred0_i;
    // Oldest bit of the chosen path: it leaves the window on this step.
    assign drop_o = pick[WINDOW-1];
    assign surv_o = surv_q;

    always_comb begin
        surv_d = surv_q;
        if (clear_i) begin
            surv_d = '0;
        end else if (advance_i) begin
            surv_d = {pick[WINDOW-2:0], NEW_BIT};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            surv_q <= '0;
        end else begin
            surv_q <= surv_d;
        end
    end

endmodule

// File: rtl/rex_exchange.sv
module rex_exchange
    import rex_pkg::*;
#(
    parameter int unsigned N_STATES = REX_STATES,
    parameter int unsigned WINDOW   = REX_WINDOW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                advance_i,
    input  logic [N_STATES-1:0] decision_i,
    output logic [N_STATES-1:0] drop_o,
    output logic [WINDOW-1:0]   home_o
);

    logic [WINDOW-1:0] surv [N_STATES];

    for (genvar n = 0; n < N_STATES; n++) begin : g_state
        localparam int unsigned P0      = pred_base(n, N_STATES);
        localparam int unsigned P1      = P0 + 1;
        localparam logic        NEW_BIT = (n >= N_STATES / 2);

        rex_cell #(
            .WINDOW (WINDOW),
            .NEW_BIT(NEW_BIT)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (clear_i),
            .advance_i(advance_i),
            .sel_i    (decision_i[n]),
            .pred0_i  (surv[P0]),
            .pred1_i  (surv[P1]),
            .surv_o   (surv[n]),
            .drop_o   (drop_o[n])
        );
    end

    assign home_o = surv[0];

endmodule

// File: rtl/rex_argmin.sv
module rex_argmin
    import rex_pkg::*;
#(
    parameter int unsigned N_STATES = REX_STATES,
    parameter int unsigned METRIC_W = REX_METRIC_W
) (
    input  logic [N_STATES*METRIC_W-1:0]  metrics_i,
    output logic [$clog2(N_STATES)-1:0]   best_o
);

    localparam int unsigned SB = $clog2(N_STATES);

    logic [METRIC_W-1:0] lead_m;

    // Strict less-than keeps the lowest index among equal metrics.
    always_comb begin
        best_o = '0;
        lead_m = metrics_i[METRIC_W-1:0];
        for (int i = 1; i < N_STATES; i++) begin
            if (metrics_i[i*METRIC_W +: METRIC_W] < lead_m) begin
                lead_m = metrics_i[i*METRIC_W +: METRIC_W];
                best_o = SB'(i);
            end
        end
    end

endmodule

// File: rtl/rex_smu.sv
module rex_smu
    import rex_pkg::*;
#(
    parameter int unsigned N_STATES = REX_STATES,
    parameter int unsigned WINDOW   = REX_WINDOW,
    parameter int unsigned METRIC_W = REX_METRIC_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_start_i,
    input  logic                         step_valid_i,
    input  logic                         frame_last_i,
    input  logic [N_STATES-1:0]          decision_i,
    input  logic [N_STATES*METRIC_W-1:0] path_metrics_i,
    output logic                         bit_o,
    output logic                         bit_valid_o,
    output logic                         frame_done_o
);

    localparam int unsigned SB = $clog2(N_STATES);
    localparam int unsigned CW = $clog2(WINDOW + 1);
    localparam int unsigned IW = $clog2(WINDOW);

    typedef struct packed {
        logic [CW-1:0] fill;
        logic          flushing;
        logic [CW-1:0] flush_cnt;
        logic          out_bit;
        logic          out_valid;
        logic          done;
    } ctl_t;

    ctl_t                ctl_d;
    ctl_t                ctl_q;
    logic                advance;
    logic                flushing;
    logic [SB-1:0]       best;
    logic [N_STATES-1:0] drop_bits;
    logic [WINDOW-1:0]   home_surv;
    logic [IW-1:0]       flush_idx;

    assign flushing  = ctl_q.flushing;
    assign advance   = step_valid_i && !frame_start_i && !ctl_q.flushing;
    assign flush_idx = IW'(ctl_q.flush_cnt - CW'(1));

    rex_argmin #(
        .N_STATES(N_STATES),
        .METRIC_W(METRIC_W)
    ) u_argmin (
        .metrics_i(path_metrics_i),
        .best_o   (best)
    );

    rex_exchange #(
        .N_STATES(N_STATES),
        .WINDOW  (WINDOW)
    ) u_exchange (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (frame_start_i),
        .advance_i (advance),
        .decision_i(decision_i),
        .drop_o    (drop_bits),
        .home_o    (home_surv)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.out_valid = 1'b0;
        ctl_d.done      = 1'b0;
        if (frame_start_i) begin
            ctl_d = '0;
        end else if (ctl_q.flushing) begin
            // Drain the state 0 survivor, oldest held bit first.
            ctl_d.out_valid = 1'b1;
            ctl_d.out_bit   = home_surv[flush_idx];
            ctl_d.flush_cnt = ctl_q.flush_cnt - CW'(1);
            if (ctl_q.flush_cnt == CW'(1)) begin
                ctl_d.flushing = 1'b0;
                ctl_d.done     = 1'b1;
                ctl_d.fill     = '0;
            end
        end else if (step_valid_i) begin
            if (ctl_q.fill == CW'(WINDOW)) begin
                ctl_d.out_valid = 1'b1;
                ctl_d.out_bit   = drop_bits[best];
            end else begin
                ctl_d.fill = ctl_q.fill + CW'(1);
            end
            if (frame_last_i) begin
                ctl_d.flushing  = 1'b1;
                ctl_d.flush_cnt = ctl_d.fill;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bit_o        = ctl_q.out_bit;
    assign bit_valid_o  = ctl_q.out_valid;
    assign frame_done_o = ctl_q.done;

endmodule

// File: rtl/rex_smu_chk.sv
module rex_smu_chk #(
    parameter int unsigned WINDOW = 32
) (
    input logic clk,
    input logic rst_n,
    input logic frame_start_i,
    input logic step_valid_i,
    input logic flushing,
    input logic bit_valid_o,
    input logic frame_done_o
);

    localparam int unsigned SW = $clog2(WINDOW + 2);

    logic [SW-1:0] steps;

    // Steps accepted in the current frame, saturating just past the window.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steps <= '0;
        end else if (frame_start_i) begin
            steps <= '0;
        end else if (frame_done_o) begin
            steps <= SW'(step_valid_i);
        end else if (step_valid_i && !flushing && steps != SW'(WINDOW + 1)) begin
            steps <= steps + SW'(1);
        end
    end

    AST_SILENT_UNTIL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_o && !flushing && !frame_done_o) |-> (steps > SW'(WINDOW))); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_valid_i && !flushing) |=> !bit_valid_o); // R8

    AST_START_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (!bit_valid_o && !frame_done_o)); // R9

    AST_DONE_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> bit_valid_o); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o); // R7

    AST_FLUSH_STREAMS: assert property (@(posedge clk) disable iff (!rst_n)
        (flushing && !frame_start_i) |=> bit_valid_o); // R6

endmodule

bind rex_smu rex_smu_chk #(
    .WINDOW(WINDOW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start_i(frame_start_i),
    .step_valid_i (step_valid_i),
    .flushing     (flushing),
    .bit_valid_o  (bit_valid_o),
    .frame_done_o (frame_done_o)
);

// File: tb/rex_smu_test.sv
module rex_smu_test;

    localparam int NS = 16;
    localparam int W  = 32;
    localparam int MW = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              frame_start;
    logic              step_valid;
    logic              frame_last;
    logic [NS-1:0]     decision;
    logic [NS*MW-1:0]  path_metrics;
    logic              bit_o;
    logic              bit_valid_o;
    logic              frame_done_o;

    always #10 clk = ~clk;

    rex_smu #(
        .N_STATES(NS),
        .WINDOW  (W),
        .METRIC_W(MW)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start),
        .step_valid_i  (step_valid),
        .frame_last_i  (frame_last),
        .decision_i    (decision),
        .path_metrics_i(path_metrics),
        .bit_o         (bit_o),
        .bit_valid_o   (bit_valid_o),
        .frame_done_o  (frame_done_o)
    );

    int          checks = 0;
    int          fails = 0;
    logic        exp_bits [0:255];
    int          exp_len = 0;
    int          out_idx = 0;
    int          done_seen = 0;
    int          latched = 0;
    int          base = 0;
    int          cyc = 0;
    string       cur_tag = "R4";
    logic [3:0]  enc = 4'd0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    task automatic rnd(output logic [31:0] v);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        v = lfsr;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Bench-side count of accepted steps, used for the R3 latency check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && step_valid && !frame_start) latched <= latched + 1;
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && bit_valid_o) begin
            if (out_idx < exp_len && out_idx < 256)
                check(bit_o == exp_bits[out_idx], $sformatf("%s bit %0d", cur_tag, out_idx),
                      int'(bit_o), int'(exp_bits[out_idx]));
            else
                check(1'b0, "R6 surplus bit", out_idx + 1, exp_len);
            if (out_idx == 0 && exp_len > W)
                check(latched - base == W + 1, "R3 first output step", latched - base, W + 1);
            out_idx++;
        end
        if (rst_n && frame_done_o) begin
            done_seen++;
            check(bit_valid_o && out_idx == exp_len, "R7 done with final bit", out_idx, exp_len);
        end
    end

    task automatic idle_cycle();
        logic [31:0] r;
        @(negedge clk);
        step_valid  = 1'b0;
        frame_last  = 1'b0;
        frame_start = 1'b0;
        rnd(r);
        decision = r[NS-1:0];
        for (int i = 0; i < NS; i++) begin
            rnd(r);
            path_metrics[i*MW +: MW] = r[MW-1:0];
        end
    endtask

    // One step of a true encoder path: R2 exchange convention.
    task automatic do_step(input logic u, input logic last, input bit tie);
        logic [3:0]  nxt;
        logic [31:0] r;
        nxt = {u, enc[3:1]};
        @(negedge clk);
        frame_start = 1'b0;
        rnd(r);
        decision      = r[NS-1:0];
        decision[nxt] = enc[0];
        for (int i = 0; i < NS; i++) begin
            rnd(r);
            if (tie)
                path_metrics[i*MW +: MW] = (i >= int'(nxt)) ? 8'd5 : 8'd9;
            else if (i == int'(nxt))
                path_metrics[i*MW +: MW] = {6'd0, r[1:0]};
            else
                path_metrics[i*MW +: MW] = 8'd4 + {5'd0, r[2:0]};
        end
        step_valid = 1'b1;
        frame_last = last;
        enc        = nxt;
    endtask

    task automatic load_frame(input int len, input bit tail);
        logic [31:0] r;
        for (int k = 0; k < len; k++) begin
            rnd(r);
            exp_bits[k] = (tail && k >= len - 4) ? 1'b0 : r[5];
        end
        exp_len   = len;
        out_idx   = 0;
        done_seen = 0;
        base      = latched;
        enc       = 4'd0;
    endtask

    task automatic run_frame(input int len, input bit tie, input bit gaps,
                             input bit noise, input bit use_start, input string tag);
        logic [31:0] r;
        int t;
        cur_tag = tag;
        load_frame(len, 1'b1);
        if (use_start) begin
            @(negedge clk);
            step_valid  = 1'b0;
            frame_start = 1'b1;
        end
        for (int k = 0; k < len; k++) begin
            rnd(r);
            if (gaps && r[1:0] == 2'd0) begin
                idle_cycle();
                if (r[2]) idle_cycle();
            end
            do_step(exp_bits[k], k == len - 1, tie);
        end
        if (noise) begin
            // R10: steps during the drain must be ignored.
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                rnd(r);
                decision   = r[NS-1:0];
                frame_last = r[7];
                step_valid = 1'b1;
            end
        end
        idle_cycle();
        t = 0;
        while (done_seen == 0 && t < 400) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        check(out_idx == exp_len, $sformatf("R6 bit count (%s)", tag), out_idx, exp_len);
        check(done_seen == 1, "R7 one done pulse", done_seen, 1);
        check(!frame_done_o && !bit_valid_o, "R7 quiet after frame", int'(frame_done_o), 0);
    endtask

    initial begin
        rst_n        = 1'b0;
        frame_start  = 1'b0;
        step_valid   = 1'b0;
        frame_last   = 1'b0;
        decision     = '0;
        path_metrics = '0;
        repeat (3) @(negedge clk);
        check(!bit_valid_o && !frame_done_o, "R1 outputs low in reset", int'(bit_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!bit_valid_o && !frame_done_o, "R1 outputs low after reset", int'(bit_valid_o), 0);

        run_frame(60, 1'b0, 1'b0, 1'b0, 1'b1, "R2 R4 main");
        run_frame(10, 1'b0, 1'b0, 1'b0, 1'b1, "R6 short");
        run_frame(32, 1'b0, 1'b0, 1'b0, 1'b1, "R3 R6 exact window");
        run_frame(33, 1'b0, 1'b0, 1'b0, 1'b1, "R3 one past window");
        run_frame(80, 1'b1, 1'b0, 1'b0, 1'b1, "R5 tie");
        run_frame(70, 1'b0, 1'b1, 1'b0, 1'b1, "R8 gaps");
        run_frame(50, 1'b0, 1'b0, 1'b1, 1'b1, "R10 drain noise");

        // R9: abandon a frame part-way, then decode a fresh one.
        cur_tag = "R9 abandoned";
        load_frame(40, 1'b0);
        @(negedge clk);
        step_valid  = 1'b0;
        frame_start = 1'b1;
        for (int k = 0; k < 40; k++) do_step(exp_bits[k], 1'b0, 1'b0);
        @(negedge clk);
        step_valid  = 1'b0;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check(!bit_valid_o && !frame_done_o, "R9 quiet after start", int'(bit_valid_o), 0);
        check(out_idx == 8, "R3 bits from 40 steps", out_idx, 8);
        run_frame(45, 1'b0, 1'b0, 1'b0, 1'b0, "R9 after abandon");

        // R7: next frame starts without a frame-start strobe.
        run_frame(40, 1'b0, 1'b1, 1'b0, 1'b0, "R7 back to back");

        finish_run();
    end

endmodule